// File: doc/BRIEF.md
# Memory-Mapped 64-bit Global Timer

This block is a free-running 64-bit up-counter with one 64-bit comparator. It sits behind a single-cycle 32-bit register port. Software starts the counter and can divide its rate with an 8-bit prescaler. It loads a compare value, and each time the counter reaches that value it gets a sticky event flag and, if enabled, an interrupt. With the auto-step mode on, the comparator adds a programmable 32-bit step to itself on every match. Periodic events then repeat at a fixed spacing with no software reload.

The count is read as two separate 32-bit words and is not latched. A carry out of the low word between two reads shows up as a changed high word on the next read of the high offset. Software detects a torn read by reading high, low, high. Register offsets (byte addresses): count low 0x00, count high 0x04, control 0x08, status 0x0C, compare low 0x10, compare high 0x14, step 0x18. Any other offset reads zero and ignores writes.

Top module: `gtmr_top`

## Requirements
- R1: After reset every register offset reads zero and `irq` is low.
- R2: With control bit 0 (run) set and prescale 0, the count goes up by one on every clock. Offset 0x00 returns count bits 31:0 and offset 0x04 returns bits 63:32, so a carry out of the low word appears in the high word on the next read.
- R3: Control bits 15:8 hold the prescale value P. While running, the count goes up once every P+1 clocks, starting P+1 clocks after the run bit is set.
- R4: The count holds while the run bit is 0. Writes to 0x00 or 0x04 load that half of the count only while the run bit is 0, and are ignored while it is 1.
- R5: Control at 0x08 reads back bit 0 run, bit 1 compare enable, bit 2 interrupt enable, bit 3 auto-step and bits 15:8 prescale. All other bits read 0.
- R6: A match happens when compare is enabled, the comparator is armed and count >= comparator. A match sets status bit 0 on the next clock, whatever the interrupt enable is.
- R7: Writing 1 to status bit 0 at 0x0C clears the flag and writing 0 has no effect. If a match and a clearing write happen in the same cycle, the flag stays set.
- R8: `irq` equals status bit 0 AND control bit 2.
- R9: With auto-step (control bit 3) on, each match adds the 32-bit step at 0x18 to the comparator, so matches repeat every step count values.
- R10: With auto-step off, a match disarms the comparator, so the flag sets at most once per comparator write. A write to either comparator half re-arms it.
- R11: The comparator halves at 0x10 and 0x14 and the step at 0x18 read back the last value written or advanced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; read data is zero when low |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq | output | 1 | Event flag gated by the interrupt enable |

## Verification
On every cycle the assertions check several relations. The count moves by at most one while running and holds while stopped with no count write. The flag only falls after a clearing write and never drops while one is absent. An auto-step match advances the comparator by exactly the step, a one-shot match is not followed by another, and `irq` never rises without its enable and the flag. The bench scenarios show the rest. These are the exact clock in which a match first raises the flag, the prescaled rate across random prescale values and run lengths, carries from the low word into the high word, writes ignored while running, and the coincident match and clear.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  // register byte offsets; software depends on these
  localparam logic [7:0] OFF_CNT_LO = 8'h00;
  localparam logic [7:0] OFF_CNT_HI = 8'h04;
  localparam logic [7:0] OFF_CTRL   = 8'h08;
  localparam logic [7:0] OFF_STAT   = 8'h0C;
  localparam logic [7:0] OFF_CMP_LO = 8'h10;
  localparam logic [7:0] OFF_CMP_HI = 8'h14;
  localparam logic [7:0] OFF_STEP   = 8'h18;

  // control bit positions
  localparam int CB_RUN   = 0;
  localparam int CB_CMP   = 1;
  localparam int CB_IRQ   = 2;
  localparam int CB_AUTO  = 3;
  localparam int CB_PRESC = 8;
endpackage

// File: rtl/gtmr_regs.sv
module gtmr_regs #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5,
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr,
  input  logic [DATA_W-1:0]  wdata,
  output logic               run,
  output logic               cmp_en,
  output logic               irq_en,
  output logic               auto_en,
  output logic [PRESC_W-1:0] presc,
  output logic [DATA_W-1:0]  step,
  output logic               wr_cnt_lo,
  output logic               wr_cnt_hi,
  output logic               wr_cmp_lo,
  output logic               wr_cmp_hi,
  output logic               clr_flag
);
  import gtmr_pkg::*;

  logic               wr_ctrl, wr_step;
  logic [3:0]         mode_q, mode_d;
  logic [PRESC_W-1:0] presc_q, presc_d;
  logic [DATA_W-1:0]  step_q, step_d;

  // address decode
  always_comb begin
    wr_cnt_lo = wr && (addr == ADDR_W'(OFF_CNT_LO));
    wr_cnt_hi = wr && (addr == ADDR_W'(OFF_CNT_HI));
    wr_ctrl   = wr && (addr == ADDR_W'(OFF_CTRL));
    clr_flag  = wr && (addr == ADDR_W'(OFF_STAT)) && wdata[0];
    wr_cmp_lo = wr && (addr == ADDR_W'(OFF_CMP_LO));
    wr_cmp_hi = wr && (addr == ADDR_W'(OFF_CMP_HI));
    wr_step   = wr && (addr == ADDR_W'(OFF_STEP));
  end

  always_comb begin
    mode_d  = mode_q;
    presc_d = presc_q;
    step_d  = step_q;
    if (wr_ctrl) begin
      mode_d  = wdata[CB_AUTO:CB_RUN];
      presc_d = wdata[CB_PRESC +: PRESC_W];
    end
    if (wr_step) step_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      presc_q <= '0;
      step_q  <= '0;
    end else begin
      mode_q  <= mode_d;
      presc_q <= presc_d;
      step_q  <= step_d;
    end
  end

  assign run     = mode_q[CB_RUN];
  assign cmp_en  = mode_q[CB_CMP];
  assign irq_en  = mode_q[CB_IRQ];
  assign auto_en = mode_q[CB_AUTO];
  assign presc   = presc_q;
  assign step    = step_q;
endmodule

// File: rtl/gtmr_counter.sv
module gtmr_counter #(
  parameter int DATA_W  = 32,
  parameter int PRESC_W = 8,
  localparam int CNT_W  = 2 * DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [PRESC_W-1:0] presc,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [DATA_W-1:0]  wdata,
  output logic [CNT_W-1:0]   count
);
  logic [PRESC_W-1:0] div_q, div_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               tick;

  always_comb begin
    // >= keeps the divider from running past a lowered prescale
    tick  = run && (div_q >= presc);
    div_d = (!run || tick) ? '0 : div_q + PRESC_W'(1);
    cnt_d = cnt_q;
    if (tick) begin
      cnt_d = cnt_q + CNT_W'(1);
    end else if (!run) begin
      if (wr_lo) cnt_d[DATA_W-1:0]     = wdata;
      if (wr_hi) cnt_d[CNT_W-1:DATA_W] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (count == $past(count)) || (count == $past(count) + CNT_W'(1))); // R3
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_lo && !wr_hi) |=> $stable(count)); // R4
endmodule

// File: rtl/gtmr_match.sv
module gtmr_match #(
  parameter int DATA_W = 32,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count,
  input  logic              cmp_en,
  input  logic              auto_en,
  input  logic [DATA_W-1:0] step,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr_flag,
  output logic [CNT_W-1:0]  cmp,
  output logic              flag
);
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             armed_q, armed_d;
  logic             flag_q, flag_d;
  logic             hit, cmp_wr;

  always_comb begin
    cmp_wr  = wr_lo || wr_hi;
    hit     = armed_q && cmp_en && (count >= cmp_q);
    cmp_d   = cmp_q;
    armed_d = armed_q;
    if (hit) begin
      if (auto_en) cmp_d = cmp_q + CNT_W'(step);
      else         armed_d = 1'b0;
    end
    // a software write wins over the advance for its half
    if (wr_lo) cmp_d[DATA_W-1:0]     = wdata;
    if (wr_hi) cmp_d[CNT_W-1:DATA_W] = wdata;
    if (cmp_wr) armed_d = 1'b1;
    flag_d = hit || (flag_q && !clr_flag);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q   <= '0;
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      cmp_q   <= cmp_d;
      armed_q <= armed_d;
      flag_q  <= flag_d;
    end
  end

  assign cmp  = cmp_q;
  assign flag = flag_q;

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_flag) |=> flag); // R7
  AST_FLAG_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(clr_flag)); // R7
  AST_AUTO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && auto_en && !cmp_wr) |=> cmp == $past(cmp) + CNT_W'($past(step))); // R9
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !auto_en && !cmp_wr) |=> !hit); // R10
endmodule

// File: rtl/gtmr_top.sv
module gtmr_top #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5,
  parameter int PRESC_W = 8,
  localparam int CNT_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import gtmr_pkg::*;

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic               run, cmp_en, irq_en, auto_en;
  logic [PRESC_W-1:0] presc;
  logic [DATA_W-1:0]  step;
  logic               wr_cnt_lo, wr_cnt_hi, wr_cmp_lo, wr_cmp_hi, clr_flag;
  logic [CNT_W-1:0]   count, cmp;
  logic               flag;
  logic [DATA_W-1:0]  ctrl_word, rd_mux;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  gtmr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRESC_W(PRESC_W)) i_regs (
    .clk(clk), .rst_n(rst_int_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .run(run), .cmp_en(cmp_en), .irq_en(irq_en), .auto_en(auto_en),
    .presc(presc), .step(step),
    .wr_cnt_lo(wr_cnt_lo), .wr_cnt_hi(wr_cnt_hi),
    .wr_cmp_lo(wr_cmp_lo), .wr_cmp_hi(wr_cmp_hi), .clr_flag(clr_flag)
  );

  gtmr_counter #(.DATA_W(DATA_W), .PRESC_W(PRESC_W)) i_counter (
    .clk(clk), .rst_n(rst_int_n), .run(run), .presc(presc),
    .wr_lo(wr_cnt_lo), .wr_hi(wr_cnt_hi), .wdata(bus_wdata), .count(count)
  );

  gtmr_match #(.DATA_W(DATA_W)) i_match (
    .clk(clk), .rst_n(rst_int_n), .count(count), .cmp_en(cmp_en),
    .auto_en(auto_en), .step(step), .wr_lo(wr_cmp_lo), .wr_hi(wr_cmp_hi),
    .wdata(bus_wdata), .clr_flag(clr_flag), .cmp(cmp), .flag(flag)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CB_RUN]  = run;
    ctrl_word[CB_CMP]  = cmp_en;
    ctrl_word[CB_IRQ]  = irq_en;
    ctrl_word[CB_AUTO] = auto_en;
    ctrl_word[CB_PRESC +: PRESC_W] = presc;
    case (bus_addr)
      ADDR_W'(OFF_CNT_LO): rd_mux = count[DATA_W-1:0];
      ADDR_W'(OFF_CNT_HI): rd_mux = count[CNT_W-1:DATA_W];
      ADDR_W'(OFF_CTRL):   rd_mux = ctrl_word;
      ADDR_W'(OFF_STAT):   rd_mux = DATA_W'(flag);
      ADDR_W'(OFF_CMP_LO): rd_mux = cmp[DATA_W-1:0];
      ADDR_W'(OFF_CMP_HI): rd_mux = cmp[CNT_W-1:DATA_W];
      ADDR_W'(OFF_STEP):   rd_mux = step;
      default:             rd_mux = '0;
    endcase
    bus_rdata = bus_rd ? rd_mux : '0;
  end

  assign irq = flag && irq_en;

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq |-> (irq_en && flag)); // R8
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(irq) |-> ($rose(flag) || $rose(irq_en))); // R8
endmodule

// File: tb/test_gtmr_top.sv
module test_gtmr_top;
  logic        clk;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic        bus_rd;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks;
  int errors;
  bit done;

  gtmr_top i_gtmr_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // expected count after a run of `edges` active clocks with prescale p
  function automatic logic [63:0] exp_count(logic [63:0] start, int edges, int p);
    return start + 64'(edges / (p + 1));
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at a falling edge; write lands on the next rising edge
  task automatic wr(logic [4:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, lo, hi;
    logic [63:0] start;
    checks = 0; errors = 0; done = 1'b0;
    bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; bus_rd = 1'b0;
    rst_n = 1'b0;
    v = $urandom(32'd20240611);
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R1: reset state of every offset
    for (int a = 0; a <= 'h18; a += 4) begin
      rd(5'(a), v);
      check("R1", 64'(v), 64'h0);
    end
    check("R1 irq", 64'(irq), 64'h0);

    // R5: control readback, reserved bits read 0, run stays off
    wr(5'h08, 32'hFFFF_AAF6);
    rd(5'h08, v);
    check("R5", 64'(v), 64'h0000_AA06);
    wr(5'h08, 32'h0);

    // R11: comparator and step readback
    wr(5'h10, 32'h1234_5678);
    wr(5'h14, 32'hA5A5_0001);
    wr(5'h18, 32'h0000_00C3);
    rd(5'h10, v); check("R11 cmp lo", 64'(v), 64'h1234_5678);
    rd(5'h14, v); check("R11 cmp hi", 64'(v), 64'hA5A5_0001);
    rd(5'h18, v); check("R11 step", 64'(v), 64'hC3);
    wr(5'h14, 32'h0);
    wr(5'h18, 32'h0);

    // R2: carry from low into high word
    wr(5'h00, 32'hFFFF_FFFF);
    wr(5'h04, 32'h0000_0005);
    wr(5'h08, 32'h1);
    rd(5'h00, lo); check("R2 lo before carry", 64'(lo), 64'hFFFF_FFFF);
    rd(5'h04, hi); check("R2 hi before carry", 64'(hi), 64'h5);
    idle(1);
    rd(5'h04, hi); check("R2 hi after carry", 64'(hi), 64'h6);
    rd(5'h00, lo); check("R2 lo after carry", 64'(lo), 64'h0);
    idle(3);
    rd(5'h00, lo); check("R2 one per clock", 64'(lo), 64'h3);
    wr(5'h08, 32'h0);

    // R4: count holds while stopped
    rd(5'h00, lo);
    idle(7);
    rd(5'h00, v); check("R4 hold", 64'(v), 64'(lo));

    // R3, R4: random prescale and run length, write ignored while running
    for (int it = 0; it < 12; it++) begin
      int p, n;
      p = int'($urandom % 6);
      n = int'($urandom % 50);
      start = {$urandom, 32'hFFFF_FFE0 | ($urandom & 32'h1F)};
      wr(5'h00, start[31:0]);
      wr(5'h04, start[63:32]);
      wr(5'h08, {16'h0, 8'(p), 8'h01});
      wr(5'h04, $urandom);        // ignored: run bit is set
      idle(n);
      wr(5'h08, 32'h0);
      rd(5'h00, lo);
      rd(5'h04, hi);
      check("R3/R4 prescaled count", {hi, lo}, exp_count(start, n + 2, p));
    end

    // R6, R8, R10: one-shot match
    wr(5'h00, 32'h0);
    wr(5'h04, 32'h0);
    wr(5'h10, 32'd10);
    wr(5'h14, 32'h0);
    wr(5'h08, 32'h7);
    idle(10);
    rd(5'h0C, v); check("R6 no flag before match", 64'(v), 64'h0);
    check("R8 irq low", 64'(irq), 64'h0);
    idle(1);
    rd(5'h0C, v); check("R6 flag on match", 64'(v), 64'h1);
    check("R8 irq high", 64'(irq), 64'h1);
    wr(5'h08, 32'h3);
    check("R8 irq masked", 64'(irq), 64'h0);
    rd(5'h0C, v); check("R6 flag kept without irq enable", 64'(v), 64'h1);
    wr(5'h0C, 32'h0);
    rd(5'h0C, v); check("R7 write 0 no effect", 64'(v), 64'h1);
    wr(5'h0C, 32'h1);
    rd(5'h0C, v); check("R7 clear", 64'(v), 64'h0);
    idle(5);
    rd(5'h0C, v); check("R10 no re-fire", 64'(v), 64'h0);
    wr(5'h10, 32'd5);
    rd(5'h0C, v); check("R10 not yet", 64'(v), 64'h0);
    idle(1);
    rd(5'h0C, v); check("R10 re-armed by write", 64'(v), 64'h1);
    check("R8 irq stays masked", 64'(irq), 64'h0);

    // R9: auto-step period
    wr(5'h08, 32'h0);
    wr(5'h0C, 32'h1);
    wr(5'h00, 32'h0);
    wr(5'h04, 32'h0);
    wr(5'h10, 32'd20);
    wr(5'h18, 32'd7);
    wr(5'h08, 32'hF);
    idle(20);
    rd(5'h0C, v); check("R9 before first match", 64'(v), 64'h0);
    idle(1);
    rd(5'h0C, v); check("R9 first match", 64'(v), 64'h1);
    rd(5'h10, v); check("R9 cmp advanced", 64'(v), 64'd27);
    wr(5'h0C, 32'h1);
    rd(5'h0C, v); check("R9 cleared", 64'(v), 64'h0);
    idle(5);
    rd(5'h0C, v); check("R9 before second match", 64'(v), 64'h0);
    idle(1);
    rd(5'h0C, v); check("R9 second match", 64'(v), 64'h1);
    rd(5'h10, v); check("R9 cmp advanced again", 64'(v), 64'd34);

    // R7: clear coincident with a match keeps the flag
    wr(5'h08, 32'h0);
    wr(5'h18, 32'h0);
    wr(5'h08, 32'hB);
    wr(5'h10, 32'h0);
    idle(2);
    wr(5'h0C, 32'h1);
    rd(5'h0C, v); check("R7 match beats clear", 64'(v), 64'h1);
    check("R8 irq off", 64'(irq), 64'h0);
    wr(5'h08, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule